// File: doc/BRIEF.md
# Boot-Time Register Write Sequencer

This block is a write-only APB requester that runs once each time reset is released. It walks a constant table of 64-bit entries fixed at elaboration, starting at index 0 and moving upward. Each entry becomes exactly one APB write. The upper 32 bits of an entry are the target address and the lower 32 bits are the write data. No host or software is involved. When the final write has been accepted, a completion flag rises in the APB clock domain and stays high. Downstream logic, such as an Ethernet MAC that needs its configuration first, can hold off until that flag is set.

The only flow-controlled interface is the APB request. The completer applies back-pressure by holding PREADY low during the access phase. While it does so, the sequencer keeps every request signal steady and waits for as many cycles as needed. An error response does not stop the walk. It sets a sticky error flag, and the next entry is issued as usual. The completion and error outputs are plain level signals.

Top module: `regboot_seq_top`

## Requirements
- R1: For each table entry, PADDR carries bits [63:32] and PWDATA carries bits [31:0]. For example, the entry 64'h1000_0020_0000_00FF writes 32'h0000_00FF to address 32'h1000_0020.
- R2: Entries are written in ascending index order, starting at index 0, with exactly one completed write per entry and no other transfers.
- R3: Every write starts with a single setup cycle (PSEL=1, PENABLE=0), and the access phase (PSEL=1, PENABLE=1) follows on the next cycle.
- R4: The access phase lasts until PREADY is sampled at 1. During wait states, PADDR and PWDATA stay unchanged.
- R5: PWRITE is 1 and PSTRB is 4'b1111 whenever PSEL is 1.
- R6: init_done is 0 until the last write completes. It becomes 1 on the clock edge where PREADY=1 ends the last access phase.
- R7: Once init_done is 1, it stays 1 and PSEL stays 0 until the next reset.
- R8: With an empty table (ENTRY_COUNT=0), no transfer takes place, and init_done becomes 1 at the first clock edge after reset is released.
- R9: A write that completes with PSLVERR=1 sets init_err at that clock edge. init_err stays 1 until reset, and the next entry is still issued.
- R10: While PRESETn is low, PSEL, PENABLE, init_done and init_err are all 0.
- R11: With a non-empty table, the setup phase of entry 0 begins at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset, synchronous to pclk |
| paddr | output | 32 | Write address taken from the entry in flight |
| psel | output | 1 | Completer select |
| penable | output | 1 | Access-phase marker |
| pwrite | output | 1 | Transfer direction, always write |
| pwdata | output | 32 | Write data taken from the entry in flight |
| pstrb | output | 4 | Byte strobes, always all ones |
| pready | input | 1 | Completer ready, ends the access phase |
| pslverr | input | 1 | Completer error response, sampled with pready |
| init_done | output | 1 | Sticky flag: all table writes have finished |
| init_err | output | 1 | Sticky flag: at least one write got an error response |

## Verification
Reset release is at a falling edge. The setup phase of entry 0 is then visible at the next falling edge, and every later setup phase appears one cycle after the previous access completed. init_done and init_err change on the same rising edge that samples the completing PREADY, so the bench checks them at the falling edge half a cycle later. It also confirms that both are still low at the falling edge where PREADY is first driven high. The bench drives PREADY and PSLVERR, and samples all outputs, only at falling edges. This places every check away from the rising edge that the design uses. The completer model adds a different number of wait states to each write, including zero and several, so the hold rule and the one-cycle advance are both exercised.

// File: rtl/regboot_pkg.sv
package regboot_pkg;

  localparam int unsigned ENTRY_W = 64;
  localparam int unsigned AW      = 32;
  localparam int unsigned DW      = 32;
  localparam int unsigned SW      = DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } init_entry_t;

  // upper half is the target address, lower half the payload
  function automatic init_entry_t split_entry(input logic [ENTRY_W-1:0] raw);
    init_entry_t e;
    e.addr = raw[ENTRY_W-1 -: AW];
    e.data = raw[DW-1:0];
    return e;
  endfunction

endpackage

// File: rtl/regboot_table.sv
module regboot_table
  import regboot_pkg::*;
#(
  parameter int unsigned ENTRY_COUNT = 4,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned TBL_W       = 256,
  parameter logic [TBL_W-1:0] INIT_TABLE = '0
) (
  input  logic [IDX_W-1:0] idx,
  output init_entry_t      entry
);

  generate
    if (ENTRY_COUNT == 0) begin : g_empty
      assign entry = '0;
    end else begin : g_rom
      init_entry_t rows [ENTRY_COUNT];
      for (genvar i = 0; i < ENTRY_COUNT; i++) begin : g_row
        assign rows[i] = split_entry(INIT_TABLE[i*ENTRY_W +: ENTRY_W]);
      end
      always_comb begin
        entry = '0;
        for (int j = 0; j < ENTRY_COUNT; j++) begin
          if (idx == IDX_W'(j)) entry = rows[j];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/regboot_cursor.sv
module regboot_cursor #(
  parameter int unsigned ENTRY_COUNT = 4,
  parameter int unsigned IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             is_last
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       idx_q <= '0;
    else if (advance) idx_q <= idx_q + 1'b1;
  end

  assign idx = idx_q;

  generate
    if (ENTRY_COUNT == 0) begin : g_none
      assign is_last = 1'b1;
    end else begin : g_cmp
      localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_COUNT - 1);
      assign is_last = (idx_q == LAST_IDX);
    end
  endgenerate

endmodule

// File: rtl/regboot_apb_fsm.sv
module regboot_apb_fsm
  import regboot_pkg::*;
#(
  parameter bit EMPTY_TABLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_last,
  input  logic pready,
  input  logic pslverr,
  output logic advance,
  output logic psel,
  output logic penable,
  output logic done,
  output logic err
);

  seq_state_e state_q, state_d;
  logic       err_q;
  logic       xfer_end;

  assign xfer_end = (state_q == ST_ACCESS) && pready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   state_d = EMPTY_TABLE ? ST_DONE : ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (pready) state_d = is_last ? ST_DONE : ST_SETUP;
      ST_DONE:   state_d = ST_DONE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (xfer_end && pslverr) err_q <= 1'b1;
    end
  end

  assign advance = xfer_end && !is_last;
  assign psel    = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
  assign penable = (state_q == ST_ACCESS);
  assign done    = (state_q == ST_DONE);
  assign err     = err_q;

endmodule

// File: rtl/regboot_seq_top.sv
module regboot_seq_top
  import regboot_pkg::*;
#(
  parameter int unsigned ENTRY_COUNT = 4,
  parameter int unsigned TBL_W = (ENTRY_COUNT == 0) ? ENTRY_W : ENTRY_COUNT * ENTRY_W,
  parameter logic [TBL_W-1:0] INIT_TABLE = {
    64'h1000_0100_0000_0003,
    64'h1000_0040_DEAD_BEEF,
    64'h2000_0004_0000_0001,
    64'h1000_0020_0000_00FF
  }
) (
  input  logic          pclk,
  input  logic          presetn,
  output logic [AW-1:0] paddr,
  output logic          psel,
  output logic          penable,
  output logic          pwrite,
  output logic [DW-1:0] pwdata,
  output logic [SW-1:0] pstrb,
  input  logic          pready,
  input  logic          pslverr,
  output logic          init_done,
  output logic          init_err
);

  localparam int unsigned IDX_W = (ENTRY_COUNT <= 1) ? 1 : $clog2(ENTRY_COUNT);
  localparam bit EMPTY = (ENTRY_COUNT == 0);

  logic [IDX_W-1:0] idx;
  logic             is_last;
  logic             advance;
  init_entry_t      cur;

  regboot_cursor #(
    .ENTRY_COUNT (ENTRY_COUNT),
    .IDX_W       (IDX_W)
  ) u_cursor (
    .clk     (pclk),
    .rst_n   (presetn),
    .advance (advance),
    .idx     (idx),
    .is_last (is_last)
  );

  regboot_table #(
    .ENTRY_COUNT (ENTRY_COUNT),
    .IDX_W       (IDX_W),
    .TBL_W       (TBL_W),
    .INIT_TABLE  (INIT_TABLE)
  ) u_table (
    .idx   (idx),
    .entry (cur)
  );

  regboot_apb_fsm #(
    .EMPTY_TABLE (EMPTY)
  ) u_fsm (
    .clk     (pclk),
    .rst_n   (presetn),
    .is_last (is_last),
    .pready  (pready),
    .pslverr (pslverr),
    .advance (advance),
    .psel    (psel),
    .penable (penable),
    .done    (init_done),
    .err     (init_err)
  );

  assign paddr  = cur.addr;
  assign pwdata = cur.data;
  assign pwrite = 1'b1;
  assign pstrb  = '1;

endmodule

// File: rtl/regboot_seq_checker.sv
module regboot_seq_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 4
) (
  input logic          pclk,
  input logic          presetn,
  input logic [AW-1:0] paddr,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [DW-1:0] pwdata,
  input logic [SW-1:0] pstrb,
  input logic          pready,
  input logic          init_done,
  input logic          init_err
);

  a_r3_setup_then_access: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable) |=> (psel && penable));

  a_r3_enable_needs_select: assert property (@(posedge pclk) disable iff (!presetn)
    penable |-> psel);

  a_r4_hold_until_ready: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr) && $stable(pwdata)));

  a_r5_write_only: assert property (@(posedge pclk) disable iff (!presetn)
    psel |-> (pwrite && (pstrb == '1)));

  a_r7_done_sticky: assert property (@(posedge pclk) disable iff (!presetn)
    init_done |=> init_done);

  a_r7_quiet_after_done: assert property (@(posedge pclk) disable iff (!presetn)
    init_done |-> !psel);

  a_r9_err_sticky: assert property (@(posedge pclk) disable iff (!presetn)
    init_err |=> init_err);

endmodule

bind regboot_seq_top regboot_seq_checker #(
  .AW (regboot_pkg::AW),
  .DW (regboot_pkg::DW),
  .SW (regboot_pkg::SW)
) u_checker (
  .pclk      (pclk),
  .presetn   (presetn),
  .paddr     (paddr),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .pwdata    (pwdata),
  .pstrb     (pstrb),
  .pready    (pready),
  .init_done (init_done),
  .init_err  (init_err)
);

// File: tb/regboot_seq_top_bench.sv
module regboot_seq_top_bench;

  localparam int N = 4;
  localparam logic [N*64-1:0] TBL = {
    64'h1000_0100_0000_0003,
    64'h1000_0040_DEAD_BEEF,
    64'h2000_0004_0000_0001,
    64'h1000_0020_0000_00FF
  };
  localparam int WAITS [N] = '{0, 2, 0, 5};
  localparam int ERR_IDX = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] paddr, pwdata;
  logic        psel, penable, pwrite;
  logic [3:0]  pstrb;
  logic        pready = 1'b0;
  logic        pslverr = 1'b0;
  logic        done, err;

  logic [31:0] z_paddr, z_pwdata;
  logic        z_psel, z_penable, z_pwrite, z_done, z_err;
  logic [3:0]  z_pstrb;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q [$];

  always #2 clk = ~clk;

  regboot_seq_top #(.ENTRY_COUNT(N), .INIT_TABLE(TBL)) u_regboot_seq_top (
    .pclk(clk), .presetn(rst_n), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .pstrb(pstrb), .pready(pready),
    .pslverr(pslverr), .init_done(done), .init_err(err)
  );

  regboot_seq_top #(.ENTRY_COUNT(0), .INIT_TABLE(64'h0)) u_zero (
    .pclk(clk), .presetn(rst_n), .paddr(z_paddr), .psel(z_psel), .penable(z_penable),
    .pwrite(z_pwrite), .pwdata(z_pwdata), .pstrb(z_pstrb), .pready(1'b0),
    .pslverr(1'b0), .init_done(z_done), .init_err(z_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_expected();
    for (int i = 0; i < N; i++) exp_q.push_back(TBL[i*64 +: 64]);
  endtask

  // completer model and monitor, both on the falling edge
  int  txn = 0;
  int  wcnt = 0;
  int  setup_cnt = 0;
  bit  last_ended = 1'b0;
  bit  err_ended  = 1'b0;
  bit  active = 1'b0;
  logic [31:0] held_addr, held_data;

  always @(negedge clk) begin
    if (active) begin
      if (last_ended) begin
        check(done === 1'b1, "R6 done after last write", {63'b0, done}, 64'd1);
        last_ended = 1'b0;
      end
      if (err_ended) begin
        check(err === 1'b1, "R9 err set after error response", {63'b0, err}, 64'd1);
        err_ended = 1'b0;
      end
      pready  = 1'b0;
      pslverr = 1'b0;
      if (psel && !penable) begin
        setup_cnt++;
        held_addr = paddr;
        held_data = pwdata;
        wcnt = 0;
        check(pwrite === 1'b1 && pstrb === 4'hF, "R5 write strobes",
              {59'b0, pwrite, pstrb}, {59'b0, 1'b1, 4'hF});
      end else if (psel && penable) begin
        check(paddr === held_addr && pwdata === held_data, "R4 stable during wait",
              {paddr, pwdata}, {held_addr, held_data});
        if (txn < N && wcnt >= WAITS[txn]) begin
          logic [63:0] e;
          pready = 1'b1;
          pslverr = (txn == ERR_IDX);
          check(exp_q.size() > 0, "R2 no extra write", 64'(exp_q.size()), 64'd1);
          e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hX;
          check({paddr, pwdata} === e, "R1 R2 address and data", {paddr, pwdata}, e);
          check(setup_cnt == txn + 1, "R3 one setup per write", 64'(setup_cnt), 64'(txn + 1));
          check(done === 1'b0, "R6 done low before completion", {63'b0, done}, 64'd0);
          if (txn == ERR_IDX) begin
            check(err === 1'b0, "R9 err low before error", {63'b0, err}, 64'd0);
            err_ended = 1'b1;
          end
          if (txn == N - 1) last_ended = 1'b1;
          txn++;
        end else begin
          wcnt++;
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc++;

  initial begin
    push_expected();
    repeat (3) @(negedge clk);
    check(!psel && !penable && !done && !err, "R10 reset state",
          {60'b0, psel, penable, done, err}, 64'd0);
    check(!z_psel && !z_done, "R10 reset state empty table",
          {62'b0, z_psel, z_done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(z_done === 1'b1, "R8 empty table done", {63'b0, z_done}, 64'd1);
    check(psel === 1'b1 && penable === 1'b0, "R11 first setup", {62'b0, psel, penable}, 64'h2);
    active = 1'b1;
    while (!done && cyc < 2000) @(negedge clk);
    check(cyc < 2000, "R6 watchdog", 64'(cyc), 64'd2000);
    repeat (20) begin
      @(negedge clk);
      check(done === 1'b1 && psel === 1'b0, "R7 sticky done and idle bus",
            {62'b0, done, psel}, 64'h2);
    end
    check(txn == N, "R2 write count", 64'(txn), 64'(N));
    check(exp_q.size() == 0, "R2 all entries written", 64'(exp_q.size()), 64'd0);
    check(err === 1'b1, "R9 err sticky and walk continued", {63'b0, err}, 64'd1);
    check(z_psel === 1'b0 && z_done === 1'b1, "R8 empty table no transfer",
          {62'b0, z_psel, z_done}, 64'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule